// File: doc/BRIEF.md
# Dual-Stream Length-Framed Lane Adder

This block joins two 64-bit valid/ready streams that carry frames of equal length. A frame starts with one length word that gives the number of payload words after it. The block takes the length word from both inputs in the same cycle and forwards only the word from input A. It then adds each pair of payload words taken together from A and B and sends the sum on a single 64-bit output stream. When the payload count runs out, the next pair of words is treated as a new pair of length words.

A build parameter picks the arithmetic. In one setting each word is a single 64-bit integer. In the other setting each word holds two independent 32-bit integer lanes, and no carry passes between them. The block sits between a stream router and the rest of the datapath. It accepts a new pair of words every cycle while both inputs are valid and the output can take data. If the two length words differ, a sticky flag is set and A's length sets the size of the frame.

Top module: `dual_frame_adder`

## Requirements
- R1: After reset, `y_valid` and `len_mismatch` are 0. While either input valid is low, `a_ready` and `b_ready` are 0.
- R2: The first pair of words after reset, and the first pair after each frame ends, are length words. The output word for that pair is `a_data`, unchanged.
- R3: A pair is taken from both inputs in the same cycle. This happens only when `a_valid` and `b_valid` are both 1 and the output register is empty or `y_ready` is 1. `a_ready` and `b_ready` are always equal.
- R4: With `PACKED_LANES`=0, each payload output is `a_data + b_data` modulo 2^64.
- R5: With `PACKED_LANES`=1, output bits 31:0 are the sum of input bits 31:0 modulo 2^32. Output bits 63:32 are the sum of input bits 63:32 modulo 2^32. No carry passes from bit 31 into bit 32.
- R6: A length word of value N>0 is followed by exactly N payload outputs. The pair after those is taken as length words.
- R7: A length word of value 0 produces only the length output. The next pair is taken as length words.
- R8: If a pair of length words differ, `len_mismatch` becomes 1 in the cycle after the transfer and stays 1 until reset. The frame length is taken from A.
- R9: While `y_valid` is 1 and `y_ready` is 0, `y_valid` stays 1 and `y_data` stays stable.
- R10: While both inputs stay valid and `y_ready` stays 1, a pair is accepted every cycle, with no bubble between the length word and the payload words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_data | input | 64 | Input A word |
| a_valid | input | 1 | Input A word valid |
| a_ready | output | 1 | Input A word taken this cycle |
| b_data | input | 64 | Input B word |
| b_valid | input | 1 | Input B word valid |
| b_ready | output | 1 | Input B word taken this cycle |
| y_data | output | 64 | Output word |
| y_valid | output | 1 | Output word valid |
| y_ready | input | 1 | Downstream accepts output word |
| len_mismatch | output | 1 | Sticky flag: the A and B lengths differed |

## Verification
Two functions can fall in the same cycle. One is loading a new pair into the output register. The other is the downstream draining the word already held there, which happens when the register is full and `y_ready` is high. The bench provokes this with back-to-back frames under continuous ready and under a pseudo-random ready pattern. Each frame length from 0 to 5 is swept against words with carry-heavy corner values. The bench judges each transfer against sums it computes itself, for both a packed-lane instance and a full-width instance. It checks that no word is dropped or repeated, that a word held under a stall does not change, and that continuous traffic has no stall cycles.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

    typedef enum logic {
        PH_LEN  = 1'b0,
        PH_BODY = 1'b1
    } phase_t;

    typedef struct packed {
        phase_t      phase;
        logic [63:0] left;
        logic        mismatch;
    } seq_state_t;

    typedef struct packed {
        logic        full;
        logic [63:0] word;
    } out_state_t;

endpackage

// File: rtl/dfa_lane_adder.sv
module dfa_lane_adder #(
    parameter int DATA_W = 64,
    parameter bit PACKED = 1'b1
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] sum
);
    localparam int LANE_W    = PACKED ? DATA_W / 2 : DATA_W;
    localparam int NUM_LANES = DATA_W / LANE_W;

    // Each lane has its own adder, so no carry crosses a lane boundary.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign sum[i*LANE_W +: LANE_W] = op_a[i*LANE_W +: LANE_W] + op_b[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/dfa_frame_seq.sv
module dfa_frame_seq
    import dfa_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] len_a,
    input  logic [DATA_W-1:0] len_b,
    output logic              at_len,
    output logic              mismatch
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            if (st_q.phase == PH_LEN) begin
                st_d.left = 64'(len_a);
                if (len_a != len_b) begin
                    st_d.mismatch = 1'b1;
                end
                if (len_a != '0) begin
                    st_d.phase = PH_BODY;
                end
            end else begin
                st_d.left = st_q.left - 64'd1;
                if (st_q.left == 64'd1) begin
                    st_d.phase = PH_LEN;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_LEN, left: '0, mismatch: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign at_len   = (st_q.phase == PH_LEN);
    assign mismatch = st_q.mismatch;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> mismatch); // R8
    AST_ZERO_LEN_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (take && at_len && len_a == '0) |=> at_len); // R7
    AST_LAST_WORD_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !at_len && st_q.left == 64'd1) |=> at_len); // R6
    AST_BODY_AFTER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (take && at_len && len_a != '0) |=> !at_len); // R6

endmodule

// File: rtl/dfa_out_reg.sv
module dfa_out_reg
    import dfa_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              drain,
    output logic              slot_free,
    output logic              full,
    output logic [DATA_W-1:0] dout
);
    out_state_t or_d, or_q;

    always_comb begin
        or_d = or_q;
        if (load) begin
            or_d.full = 1'b1;
            or_d.word = 64'(din);
        end else if (drain) begin
            or_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            or_q <= '{full: 1'b0, word: '0};
        end else begin
            or_q <= or_d;
        end
    end

    assign full      = or_q.full;
    assign dout      = or_q.word[DATA_W-1:0];
    assign slot_free = !or_q.full || drain;

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !drain) |=> (full && $stable(dout))); // R9
    AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full); // R10

endmodule

// File: rtl/dual_frame_adder.sv
module dual_frame_adder #(
    parameter int DATA_W       = 64,
    parameter bit PACKED_LANES = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_valid,
    output logic              b_ready,
    output logic [DATA_W-1:0] y_data,
    output logic              y_valid,
    input  logic              y_ready,
    output logic              len_mismatch
);
    localparam int LANE_W = PACKED_LANES ? DATA_W / 2 : DATA_W;

    logic              take;
    logic              slot_free;
    logic              at_len;
    logic [DATA_W-1:0] lane_sum;
    logic [DATA_W-1:0] next_word;

    // Both inputs move together, and only when the output register has room.
    assign take    = a_valid && b_valid && slot_free;
    assign a_ready = take;
    assign b_ready = take;

    dfa_lane_adder #(
        .DATA_W (DATA_W),
        .PACKED (PACKED_LANES)
    ) u_add (
        .op_a (a_data),
        .op_b (b_data),
        .sum  (lane_sum)
    );

    dfa_frame_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .len_a    (a_data),
        .len_b    (b_data),
        .at_len   (at_len),
        .mismatch (len_mismatch)
    );

    assign next_word = at_len ? a_data : lane_sum;

    dfa_out_reg #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .din       (next_word),
        .drain     (y_ready),
        .slot_free (slot_free),
        .full      (y_valid),
        .dout      (y_data)
    );

    AST_JOIN_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |-> (a_valid && b_valid)); // R3
    AST_JOIN_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid && !y_ready) |-> !a_ready); // R3
    AST_LEN_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && at_len) |=> (y_data == $past(a_data))); // R2
    AST_LOW_LANE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !at_len) |=> (y_data[LANE_W-1:0] ==
            LANE_W'($past(a_data[LANE_W-1:0]) + $past(b_data[LANE_W-1:0])))); // R5

endmodule

// File: tb/dual_frame_adder_test.sv
module dual_frame_adder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a_data = '0, b_data = '0;
    logic        a_valid = 1'b0, b_valid = 1'b0, y_ready = 1'b0;
    logic        a_ready, b_ready, y_valid, len_mismatch;
    logic [63:0] y_data;
    logic        w_a_ready, w_b_ready, w_y_valid, w_mismatch;
    logic [63:0] w_y_data;

    int total = 0, bad = 0, stalls = 0, rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [63:0] exp_p[$];
    logic [63:0] exp_w[$];
    int          exp_hdr[$];
    bit          lockstep_ok = 1'b1;

    always #4 clk = ~clk;

    dual_frame_adder #(.DATA_W(64), .PACKED_LANES(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .a_data(a_data), .a_valid(a_valid), .a_ready(a_ready),
        .b_data(b_data), .b_valid(b_valid), .b_ready(b_ready), .y_data(y_data),
        .y_valid(y_valid), .y_ready(y_ready), .len_mismatch(len_mismatch));

    dual_frame_adder #(.DATA_W(64), .PACKED_LANES(1'b0)) uut_wide (
        .clk(clk), .rst_n(rst_n), .a_data(a_data), .a_valid(a_valid), .a_ready(w_a_ready),
        .b_data(b_data), .b_valid(b_valid), .b_ready(w_b_ready), .y_data(w_y_data),
        .y_valid(w_y_valid), .y_ready(y_ready), .len_mismatch(w_mismatch));

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Ready pattern: 0 always high, 1 pseudo-random, 2 held low.
    initial begin
        forever begin
            step();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0: y_ready = 1'b1;
                1: y_ready = lfsr[0] | lfsr[3];
                default: y_ready = 1'b0;
            endcase
        end
    end

    function automatic logic [63:0] pat(int n);
        case (n % 8)
            0: return 64'hFFFF_FFFF_FFFF_FFFF;
            1: return 64'h0000_0000_FFFF_FFFF;
            2: return 64'h0000_0001_0000_0001;
            3: return 64'h8000_0000_8000_0000;
            4: return 64'h0;
            default: return 64'(n) * 64'h9E37_79B9_7F4A_7C15;
        endcase
    endfunction

    // Entered at negedge+1; returns at the next negedge+1 after the pair is taken.
    task automatic send(logic [63:0] a, logic [63:0] b, bit hdr);
        logic [31:0] lo, hi;
        a_data = a; b_data = b; a_valid = 1'b1; b_valid = 1'b1;
        #1;
        while (!a_ready) begin
            stalls++;
            step();
            #1;
        end
        if (a_ready != b_ready || a_ready != w_a_ready) lockstep_ok = 1'b0;
        lo = a[31:0] + b[31:0];
        hi = a[63:32] + b[63:32];
        exp_p.push_back(hdr ? a : {hi, lo});
        exp_w.push_back(hdr ? a : a + b);
        exp_hdr.push_back(hdr ? 1 : 0);
        step();
        a_valid = 1'b0; b_valid = 1'b0;
    endtask

    task automatic run_frame(int len, int lenb, int seed);
        send(64'(len), 64'(lenb), 1'b1);
        for (int k = 0; k < len; k++) begin
            send(pat(seed + 2 * k), pat(seed + 2 * k + 1), 1'b0);
        end
    endtask

    // Output monitor at negedge+3, before the next edge.
    logic        prev_stall = 1'b0;
    logic [63:0] prev_p = '0;
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (prev_stall) begin
                check(y_valid && y_data == prev_p, "R9 held word under stall", y_data, prev_p);
            end
            prev_stall = y_valid && !y_ready;
            prev_p = y_data;
            if (y_valid && y_ready) begin
                if (exp_p.size() == 0) begin
                    check(1'b0, "R6 unexpected extra output", y_data, 64'h0);
                end else begin
                    logic [63:0] ep, ew;
                    int          h;
                    ep = exp_p.pop_front();
                    ew = exp_w.pop_front();
                    h = exp_hdr.pop_front();
                    if (h == 1) begin
                        check(y_data == ep, "R2 length forwarded (packed)", y_data, ep);
                        check(w_y_data == ew, "R2 length forwarded (wide)", w_y_data, ew);
                    end else begin
                        check(y_data == ep, "R5 packed lane sum", y_data, ep);
                        check(w_y_data == ew, "R4 full-width sum", w_y_data, ew);
                    end
                    check(w_y_valid, "R3 wide instance in lockstep", 64'(w_y_valid), 64'd1);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        check(!y_valid, "R1 y_valid after reset", 64'(y_valid), 64'd0);
        check(!len_mismatch, "R1 flag after reset", 64'(len_mismatch), 64'd0);
        check(!a_ready && !b_ready, "R1 ready with no valid", 64'(a_ready), 64'd0);
        rst_n = 1'b1;
        step();

        // R3: only A valid, nothing taken.
        a_data = 64'd2; a_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #1;
            check(!a_ready && !b_ready, "R3 A alone not taken", 64'(a_ready), 64'd0);
            step();
        end
        check(!y_valid, "R3 no output from A alone", 64'(y_valid), 64'd0);
        a_valid = 1'b0;

        // R10: continuous traffic, no bubbles.
        rdy_mode = 0;
        step();
        stalls = 0;
        run_frame(8, 8, 3);
        run_frame(2, 2, 5);
        check(stalls == 0, "R10 stall cycles under full flow", 64'(stalls), 64'd0);

        // R3: output full and held, next pair must wait.
        rdy_mode = 2;
        step();
        send(64'd1, 64'd1, 1'b1);
        a_data = pat(1); b_data = pat(2); a_valid = 1'b1; b_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #1;
            check(!a_ready, "R3 pair waits while output held", 64'(a_ready), 64'd0);
            step();
        end
        rdy_mode = 0;
        send(pat(1), pat(2), 1'b0);

        // R6/R7: length sweep 0..5 with corner data and two ready patterns.
        for (int m = 0; m < 2; m++) begin
            rdy_mode = m;
            for (int len = 0; len < 6; len++) begin
                for (int s = 0; s < 8; s++) begin
                    run_frame(len, len, s + len);
                end
            end
        end
        // R7: back-to-back zero-length frames.
        run_frame(0, 0, 0);
        run_frame(0, 0, 0);
        run_frame(1, 1, 0);

        rdy_mode = 0;
        repeat (4) step();
        check(!len_mismatch, "R8 flag low with equal lengths", 64'(len_mismatch), 64'd0);

        // R8: lengths differ; A's length governs.
        run_frame(3, 5, 2);
        step();
        check(len_mismatch && w_mismatch, "R8 flag set on mismatch", 64'(len_mismatch), 64'd1);
        run_frame(2, 2, 4);
        repeat (4) step();
        check(len_mismatch, "R8 flag sticky", 64'(len_mismatch), 64'd1);

        repeat (6) step();
        check(exp_p.size() == 0, "R6 all expected outputs seen", 64'(exp_p.size()), 64'd0);
        check(lockstep_ok, "R3 ready signals equal", 64'(lockstep_ok), 64'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule